// File: doc/BRIEF.md
# Erase-Suspend Status and Resume Controller

This block governs one bank of a flash array during a sector erase that the host may pause. It takes decoded bus write cycles (bank, sector, word offset, data byte) and starts an erase, suspends it, resumes it, or runs a program, according to the data byte. It also answers read strobes with the three polled status bits that the host inspects while an operation runs. The embedded erase and program algorithms are stood in for by down-counters. The cell array and the analogue timing are not modelled.

While the erase is paused, the host may program any sector of the bank except the one being erased. Completion of that program is visible through the ready line, through the data-polling bit and through the toggle bit, in the same way as for an ordinary program. A second toggle bit identifies the paused sector: it flips only on reads from that sector while the paused-erase program is running. Resume requests that arrive when the bank is not paused have no effect. A new suspend is honoured only while the erase is actually running again.

Top module: `esusp_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `prog_ok` is all ones, `st_dq7` is 1, `st_dq6` is 0 and `st_dq2` is 0.
- R2: A write of 80h to bank `BANK_ID` while idle starts an erase of sector `wr_sect`, holding `ready` low for `ERASE_CYC` running cycles. Writes carrying another bank number are ignored.
- R3: A write of B0h while the erase runs freezes the erase countdown. `ready` stays low for exactly `SUSP_LAT` cycles after that write and then rises, with the bank paused.
- R4: `prog_ok` is all ones when idle and all zeros while any operation runs. While paused, it has exactly one zero, at bit index equal to the sector being erased.
- R5: A0h followed by a data write to the bank programs address {`wr_sect`,`wr_ofs`} when idle or paused, holding `ready` low for `PROG_CYC` cycles. When paused, a data write to the erased sector is refused and `ready` stays high.
- R6: `st_dq7` reads the complement of the programmed bit 7 at the program target while the program runs. It reads 0 on any read during a running or pausing erase. It reads the true bit 7 at the last completed program address (forgotten when a new erase starts), and reads 1 otherwise.
- R7: `st_dq6` inverts on each read of the bank while `ready` is low, and holds when `ready` is high.
- R8: `st_dq2` inverts on each read of the erased sector while a paused-erase program runs, and holds otherwise.
- R9: A write of 30h while paused resumes the erase (`ready` low on the next cycle). A further 30h while erasing, and any 30h while idle, changes nothing.
- R10: B0h is honoured only while the erase runs. It is ignored when paused or idle, and a fresh suspend after a resume takes effect with the same `SUSP_LAT` latency.
- R11: Status outputs change only on the cycle after a read strobe carrying bank `BANK_ID`. Reads of other banks leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Decoded bus write cycle |
| wr_bank | input | BANK_W | Bank number of the write |
| wr_sect | input | SECT_W | Sector number of the write |
| wr_ofs | input | OFS_W | Word offset inside the sector |
| wr_data | input | 8 | Command or program data byte |
| rd_en | input | 1 | Read strobe |
| rd_bank | input | BANK_W | Bank number of the read |
| rd_sect | input | SECT_W | Sector number of the read |
| rd_ofs | input | OFS_W | Word offset of the read |
| st_dq7 | output | 1 | Data-polling status bit |
| st_dq6 | output | 1 | Bank toggle bit |
| st_dq2 | output | 1 | Paused-sector toggle bit |
| ready | output | 1 | High when the bank accepts commands |
| prog_ok | output | NSECT | Per-sector program permission |

## Verification
The bench builds the block with four sectors, two offset bits, bank number 2, a 30-cycle erase, a 5-cycle program and a 3-cycle suspend latency. With those values, every pairing of erased sector and program sector (16 cases) fits in one run. Each pairing covers the refusal on the diagonal, both polarities of the polled bit 7, and the toggle-bit behaviour inside and outside the paused sector. The short erase also leaves room for a resume, a repeated resume, a second suspend and full completion in each case.

// File: rtl/esusp_ctrl.sv
module esusp_ctrl #(
  parameter int NSECT     = 8,
  parameter int OFS_W     = 4,
  parameter int BANK_W    = 2,
  parameter int BANK_ID   = 1,
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 6,
  parameter int SUSP_LAT  = 3,
  localparam int SECT_W   = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [SECT_W-1:0] wr_sect,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic              st_dq7,
  output logic              st_dq6,
  output logic              st_dq2,
  output logic              ready,
  output logic [NSECT-1:0]  prog_ok
);
  localparam logic [BANK_W-1:0] BANK_SEL = BANK_W'(BANK_ID);
  localparam int OMAX = (PROG_CYC > SUSP_LAT) ? PROG_CYC : SUSP_LAT;
  localparam int ECW  = $clog2(ERASE_CYC + 1);
  localparam int OCW  = $clog2(OMAX + 1);
  localparam int AW   = SECT_W + OFS_W;
  localparam logic [7:0] C_ERASE = 8'h80, C_SUSP = 8'hB0, C_RES = 8'h30, C_PGM = 8'hA0;

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_SPEND, S_SUSP, S_SPROG, S_PROG} st_t;
  st_t st;

  logic [ECW-1:0]    ecnt;
  logic [OCW-1:0]    ocnt;
  logic              arm;
  logic [SECT_W-1:0] esect;
  logic [AW-1:0]     tgt, last;
  logic              pd7, ld7, lastv;

  wire wr_hit   = wr_en && (wr_bank == BANK_SEL);
  wire rd_hit   = rd_en && (rd_bank == BANK_SEL);
  wire prog_run = (st == S_PROG) || (st == S_SPROG);
  wire erasing  = (st == S_ERASE) || (st == S_SPEND);
  wire [AW-1:0] raddr = {rd_sect, rd_ofs};

  assign ready = (st == S_IDLE) || (st == S_SUSP);

  for (genvar i = 0; i < NSECT; i++) begin : g_ok
    assign prog_ok[i] = (st == S_IDLE) || ((st == S_SUSP) && (esect != SECT_W'(i)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ecnt  <= '0;
      ocnt  <= '0;
      arm   <= 1'b0;
      esect <= '0;
      tgt   <= '0;
      last  <= '0;
      pd7   <= 1'b0;
      ld7   <= 1'b0;
      lastv <= 1'b0;
    end else begin
      case (st)
        S_ERASE: begin
          if (ecnt == ECW'(1)) st <= S_IDLE;
          else begin
            ecnt <= ecnt - ECW'(1);
            if (wr_hit && wr_data == C_SUSP) begin
              st   <= S_SPEND;
              ocnt <= OCW'(SUSP_LAT);
            end
          end
        end
        S_SPEND: begin
          if (ocnt == OCW'(1)) st <= S_SUSP;
          else ocnt <= ocnt - OCW'(1);
        end
        S_PROG, S_SPROG: begin
          if (ocnt == OCW'(1)) begin
            st    <= (st == S_SPROG) ? S_SUSP : S_IDLE;
            lastv <= 1'b1;
            last  <= tgt;
            ld7   <= pd7;
          end else ocnt <= ocnt - OCW'(1);
        end
        default: begin
          if (wr_hit) begin
            arm <= 1'b0;
            if (arm) begin
              if (st == S_IDLE || wr_sect != esect) begin
                st   <= (st == S_IDLE) ? S_PROG : S_SPROG;
                ocnt <= OCW'(PROG_CYC);
                tgt  <= {wr_sect, wr_ofs};
                pd7  <= wr_data[7];
              end
            end else if (wr_data == C_PGM) begin
              arm <= 1'b1;
            end else if (st == S_IDLE && wr_data == C_ERASE) begin
              st    <= S_ERASE;
              ecnt  <= ECW'(ERASE_CYC);
              esect <= wr_sect;
              lastv <= 1'b0;
            end else if (st == S_SUSP && wr_data == C_RES) begin
              st <= S_ERASE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_dq7 <= 1'b1;
      st_dq6 <= 1'b0;
      st_dq2 <= 1'b0;
    end else if (rd_hit) begin
      if (!ready) st_dq6 <= ~st_dq6;
      if (st == S_SPROG && rd_sect == esect) st_dq2 <= ~st_dq2;
      if (prog_run && raddr == tgt)  st_dq7 <= ~pd7;
      else if (erasing)              st_dq7 <= 1'b0;
      else if (lastv && raddr == last) st_dq7 <= ld7;
      else                           st_dq7 <= 1'b1;
    end
  end
endmodule

// File: rtl/esusp_ctrl_chk.sv
module esusp_ctrl_chk #(
  parameter int NSECT   = 8,
  parameter int BANK_W  = 2,
  parameter int BANK_ID = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [BANK_W-1:0] wr_bank,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [BANK_W-1:0] rd_bank,
  input logic              ready,
  input logic [NSECT-1:0]  prog_ok,
  input logic              st_dq6,
  input logic              st_dq2,
  input logic              arm
);
  wire wr_hit = wr_en && (wr_bank == BANK_W'(BANK_ID));
  wire rd_hit = rd_en && (rd_bank == BANK_W'(BANK_ID));
  wire paused = ready && !(&prog_ok);

  AST_PAUSE_ONE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> $countones(~prog_ok) == 1); // R4
  AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> prog_ok == '0); // R4
  AST_DQ6_FLIPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && !ready |=> st_dq6 != $past(st_dq6)); // R7
  AST_DQ6_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && ready |=> $stable(st_dq6)); // R7
  AST_DQ2_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && ready |=> $stable(st_dq2)); // R8
  AST_RESUME_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !arm && wr_data == 8'h30 && paused |=> !ready); // R9
  AST_SUSP_IGNORED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !arm && wr_data == 8'hB0 && ready |=> ready); // R10
  AST_QUIET_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(st_dq6) && $stable(st_dq2)); // R11
endmodule

bind esusp_ctrl esusp_ctrl_chk #(.NSECT(NSECT), .BANK_W(BANK_W), .BANK_ID(BANK_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
  .rd_en(rd_en), .rd_bank(rd_bank), .ready(ready), .prog_ok(prog_ok),
  .st_dq6(st_dq6), .st_dq2(st_dq2), .arm(arm));

// File: tb/esusp_ctrl_test.sv
module esusp_ctrl_test;
  localparam int NS = 4, OW = 2, BW = 2, BID = 2, EC = 30, PC = 5, SL = 3;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [BW-1:0] wr_bank = '0, rd_bank = '0;
  logic [SW-1:0] wr_sect = '0, rd_sect = '0;
  logic [OW-1:0] wr_ofs = '0, rd_ofs = '0;
  logic [7:0] wr_data = '0;
  logic st_dq7, st_dq6, st_dq2, ready;
  logic [NS-1:0] prog_ok;

  esusp_ctrl #(.NSECT(NS), .OFS_W(OW), .BANK_W(BW), .BANK_ID(BID), .ERASE_CYC(EC),
               .PROG_CYC(PC), .SUSP_LAT(SL)) uut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  int m_st = 0;            // 0 idle 1 erasing 2 paused 3 program 4 paused-program
  bit m_to_pause = 0;
  logic [SW-1:0] m_es = '0;
  logic [SW+OW-1:0] m_tgt = '0, m_last = '0;
  logic m_pd7 = 0, m_ld7 = 0, m_lv = 0;
  logic e7 = 1, e6 = 0, e2 = 0;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int s, input int o, input logic [7:0] d);
    wr_bank = BW'(bank); wr_sect = SW'(s); wr_ofs = OW'(o); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int bank, input int s, input int o, input string tag);
    logic [SW+OW-1:0] a;
    a = {SW'(s), OW'(o)};
    if (bank == BID) begin
      if (m_st == 1 || m_st == 3 || m_st == 4) e6 = ~e6;
      if (m_st == 4 && SW'(s) == m_es) e2 = ~e2;
      if ((m_st == 3 || m_st == 4) && a == m_tgt) e7 = ~m_pd7;
      else if (m_st == 1) e7 = 1'b0;
      else if (m_lv && a == m_last) e7 = m_ld7;
      else e7 = 1'b1;
    end
    rd_bank = BW'(bank); rd_sect = SW'(s); rd_ofs = OW'(o); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check({tag, " dq7"}, st_dq7, e7);
    check({tag, " dq6"}, st_dq6, e6);
    check({tag, " dq2"}, st_dq2, e2);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
    if (m_st == 3 || m_st == 4) begin
      m_lv = 1; m_last = m_tgt; m_ld7 = m_pd7;
      m_st = (m_st == 4) ? 2 : 0;
    end else if (m_st == 1) begin
      m_st = m_to_pause ? 2 : 0;
      m_to_pause = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", ready, 1);
    check("R1 prog_ok", prog_ok, 4'hF);
    check("R1 dq7", st_dq7, 1);
    check("R1 dq6", st_dq6, 0);
    check("R1 dq2", st_dq2, 0);

    wr(1, 0, 0, 8'h80);
    check("R2 other bank erase ignored", ready, 1);
    wr(BID, 0, 0, 8'h30);
    check("R9 resume while idle ignored", ready, 1);
    wr(BID, 0, 0, 8'hB0);
    check("R10 suspend while idle ignored", ready, 1);

    begin
      int n;
      wr(BID, 0, 0, 8'hA0);
      wr(BID, 1, 3, 8'h5A);
      m_st = 3; m_tgt = {2'd1, 2'd3}; m_pd7 = 1'b0;
      wait_ready(n);
      check("R5 idle program busy cycles", n, PC);
      rd(BID, 1, 3, "R6 idle program true data");
      rd(BID, 2, 0, "R6 untouched address");
    end

    for (int e = 0; e < NS; e++) begin
      int n;
      wr(BID, e, 0, 8'h80);
      m_st = 1; m_es = SW'(e); m_lv = 0;
      check("R2 erase busy", ready, 0);
      check("R4 busy mask", prog_ok, 0);
      rd(BID, e, 0, "R7 erase read");
      rd(0, e, 0, "R11 other bank read");
      wr(BID, e, 0, 8'hB0);
      m_to_pause = 1;
      wait_ready(n);
      check("R3 suspend latency", n, SL);
      check("R4 paused mask", prog_ok, 4'hF & ~(4'h1 << e));
      rd(BID, e, 1, "R7 paused read");
      wr(BID, 0, 0, 8'hB0);
      check("R10 suspend while paused ignored", ready, 1);
      check("R10 mask kept", prog_ok, 4'hF & ~(4'h1 << e));
      for (int p = 0; p < NS; p++) begin
        logic [7:0] d;
        d = 8'(((p * 5 + e) & 127) | ((((p ^ e) & 1) != 0) ? 128 : 0));
        wr(BID, 0, 0, 8'hA0);
        wr(BID, p, p, d);
        if (p == e) begin
          check("R5 program to erased sector refused", ready, 1);
          rd(BID, p, p, "R8 refused read");
        end else begin
          check("R5 paused program accepted", ready, 0);
          m_st = 4; m_tgt = {SW'(p), OW'(p)}; m_pd7 = d[7];
          rd(BID, p, p, "R6 polling complement");
          rd(BID, e, 1, "R8 erased sector toggle");
          wait_ready(n);
          check("R5 paused program done", ready, 1);
          rd(BID, p, p, "R6 polling true data");
          rd(BID, e, 0, "R8 paused hold");
        end
      end
      wr(BID, e, 0, 8'h30);
      m_st = 1;
      check("R9 resume accepted", ready, 0);
      wr(BID, e, 0, 8'h30);
      check("R9 repeated resume ready", ready, 0);
      check("R9 repeated resume mask", prog_ok, 0);
      rd(BID, e, 2, "R7 resumed read");
      wr(BID, e, 0, 8'hB0);
      m_to_pause = 1;
      wait_ready(n);
      check("R10 re-suspend latency", n, SL);
      check("R10 re-suspend mask", prog_ok, 4'hF & ~(4'h1 << e));
      wr(BID, e, 0, 8'h30);
      m_st = 1;
      wait_ready(n);
      check("R2 erase completes ready", ready, 1);
      check("R2 erase completes mask", prog_ok, 4'hF);
      rd(BID, e, 0, "R7 idle read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule